// File: doc/BRIEF.md
# Plotter Port Control and Status Register

This block sits between a byte-wide software register interface and the control lines of a raster plotter/printer parallel port. A write sets two persistent mode bits, one for plot versus print and one for simultaneous print/plot. The same write can also ask for any mix of five one-shot remote commands: end of transmission, form feed, line terminate, remote clear and remote reset. Each requested command becomes an output strobe that is held for a fixed number of clock cycles and then drops by itself. Data transfer and DMA handshaking are outside this block.

Commands are timed by a three-state machine. The states are `ST_IDLE` (no strobe), `ST_PULSE` (the strobe is driven while a cycle counter runs down) and `ST_GAP` (one quiet cycle between two strobes that follow each other). The transitions are:
- IDLE→PULSE when a write carries any command bit.
- PULSE→PULSE while the counter is not zero.
- PULSE→IDLE at the end of the count when nothing is queued.
- PULSE→GAP at the end of the count when commands are queued.
- GAP→PULSE always, launching the queued commands.

Command writes that arrive while a strobe or gap is under way are OR-merged into a one-entry queue. They are not dropped.

A status read is combinational. It returns the two mode bits and the four live port lines, each passed through a multi-stage synchroniser, plus an OK flag formed from paper present and online.

Top module: `plotter_port_ctrl`

## Requirements
- R1: After reset, plot mode and simultaneous mode both read 0 (print mode), `cmd_strobe_o` is 0, and status bits 7 and 6 are 0.
- R2: A write sets plot mode from `wr_data[7]` and simultaneous mode from `wr_data[6]`, taking effect the cycle after the write edge. The bits hold until the next write, so 0x00 selects print mode and 0x80 selects plot mode.
- R3: `wr_data[5]` has no effect, and status bit 5 always reads 0.
- R4: Command bits map to `cmd_strobe_o` at the same positions: bit4 end of transmission, bit3 form feed, bit2 line terminate, bit1 remote clear, bit0 remote reset. A command write on an idle port drives the strobe from the cycle after the write edge for exactly PULSE_CYCLES cycles, after which the strobe returns to 0.
- R5: A write that carries command bits also updates the mode bits from that same write. The commands never change the mode.
- R6: Command bits written while a strobe or gap is in progress are queued, OR-merged with anything already queued. They are issued after the current strobe, following exactly one cycle with `cmd_strobe_o` at 0. A write in the gap cycle joins the strobe that follows.
- R7: A write whose bits 4..0 are all zero starts no strobe.
- R8: The status read is {plot, simultaneous, 0, data request, ready, paper, online, OK} from bit 7 down to bit 0. Live lines appear SYNC_STAGES cycles after they change.
- R9: Status bit 0 (OK) is 1 only when paper present and online are both 1.
- R10: Reset during a strobe ends the strobe at once and discards any queued command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control write byte |
| rd_data | output | 8 | Status byte |
| dreq_i | input | 1 | Port data request line (asynchronous) |
| ready_i | input | 1 | Port ready line (asynchronous) |
| paper_i | input | 1 | Paper present line (asynchronous) |
| online_i | input | 1 | Online line (asynchronous) |
| plot_mode_o | output | 1 | Plot mode (0 = print) |
| spp_mode_o | output | 1 | Simultaneous print/plot mode |
| cmd_strobe_o | output | 5 | Remote command strobes, bit order as in R4 |

## Verification
Two functions can collide: a strobe timing out and a new command write arriving in the same cycle. The bench writes a second command exactly in the last pulse cycle of the first one. It requires the next cycle to be a quiet gap, followed by a full-width strobe of the new command. A further write in the gap cycle itself must merge into that following strobe. Mode updates carried by the same writes are checked in parallel, to confirm that neither the timing nor the queue disturbs the persistent bits.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
    localparam int CMD_W = 5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_GAP   = 2'd2
    } strobe_state_e;

    typedef struct packed {
        logic plot;
        logic spp;
    } mode_t;
endpackage

// File: rtl/ppc_sync.sv
module ppc_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stg_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_q[g] <= '0;
                end else if (g == 0) begin
                    stg_q[g] <= async_i;
                end else begin
                    stg_q[g] <= stg_q[(g > 0) ? g - 1 : 0];
                end
            end
        end
    endgenerate

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/ppc_strobe_fsm.sv
module ppc_strobe_fsm
    import ppc_pkg::*;
#(
    parameter int PULSE_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_bits,
    output logic [CMD_W-1:0] strobe_o
);
    localparam int CNT_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_CYCLES - 1);

    strobe_state_e    state_q, state_d;
    logic [CMD_W-1:0] cur_q, cur_d;
    logic [CMD_W-1:0] pend_q, pend_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CMD_W-1:0] new_cmd, pend_next;

    assign new_cmd   = cmd_valid ? cmd_bits : '0;
    assign pend_next = pend_q | new_cmd;

    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        pend_d  = pend_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (new_cmd != '0) begin
                    state_d = ST_PULSE;
                    cur_d   = new_cmd;
                    cnt_d   = LAST;
                end
            end
            ST_PULSE: begin
                pend_d = pend_next;
                if (cnt_q == '0) begin
                    state_d = (pend_next != '0) ? ST_GAP : ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_GAP: begin
                state_d = ST_PULSE;
                cur_d   = pend_next;
                pend_d  = '0;
                cnt_d   = LAST;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            pend_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            pend_q  <= pend_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        strobe_o = (state_q == ST_PULSE) ? cur_q : '0;
    end

    AST_PULSE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_PULSE) |-> cnt_q == LAST); // R4
    AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE && cnt_q != '0) |=> (state_q == ST_PULSE && $stable(strobe_o))); // R4
    AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP) |-> (strobe_o == '0 && $past(state_q) == ST_PULSE)); // R6
    AST_QUEUE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && cmd_valid && cmd_bits != '0)
            |=> (pend_q != '0 || $past(state_q) == ST_GAP)); // R6
endmodule

// File: rtl/plotter_port_ctrl.sv
module plotter_port_ctrl
    import ppc_pkg::*;
#(
    parameter int PULSE_CYCLES = 4,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       dreq_i,
    input  logic       ready_i,
    input  logic       paper_i,
    input  logic       online_i,
    output logic       plot_mode_o,
    output logic       spp_mode_o,
    output logic [4:0] cmd_strobe_o
);
    localparam int LINES = 4;

    mode_t            mode_q;
    logic [LINES-1:0] lines_s;
    logic             ok_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_en) begin
            mode_q.plot <= wr_data[7];
            mode_q.spp  <= wr_data[6];
        end
    end

    ppc_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({dreq_i, ready_i, paper_i, online_i}),
        .sync_o  (lines_s)
    );

    ppc_strobe_fsm #(.PULSE_CYCLES(PULSE_CYCLES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (wr_en),
        .cmd_bits  (wr_data[CMD_W-1:0]),
        .strobe_o  (cmd_strobe_o)
    );

    assign ok_s        = lines_s[1] & lines_s[0];
    assign rd_data     = {mode_q.plot, mode_q.spp, 1'b0, lines_s, ok_s};
    assign plot_mode_o = mode_q.plot;
    assign spp_mode_o  = mode_q.spp;

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(plot_mode_o) && $stable(spp_mode_o))); // R2
    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (plot_mode_o == $past(wr_data[7]) && spp_mode_o == $past(wr_data[6]))); // R5
endmodule

// File: tb/test_plotter_port_ctrl.sv
module test_plotter_port_ctrl;
    localparam int P = 4;
    localparam int S = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       dreq_i = 1'b0, ready_i = 1'b0, paper_i = 1'b0, online_i = 1'b0;
    logic       plot_mode_o, spp_mode_o;
    logic [4:0] cmd_strobe_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    plotter_port_ctrl #(.PULSE_CYCLES(P), .SYNC_STAGES(S)) i_plotter_port_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .dreq_i(dreq_i), .ready_i(ready_i), .paper_i(paper_i), .online_i(online_i),
        .plot_mode_o(plot_mode_o), .spp_mode_o(spp_mode_o), .cmd_strobe_o(cmd_strobe_o)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Called at a negedge; returns at the next negedge, after the write edge.
    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic t_reset();
        chk({6'd0, plot_mode_o, spp_mode_o}, 8'h00, "R1 mode");
        chk({3'd0, cmd_strobe_o}, 8'h00, "R1 strobe");
        chk(rd_data & 8'hC0, 8'h00, "R1 status mode");
    endtask

    task automatic t_mode();
        wr(8'h80);
        chk({6'd0, plot_mode_o, spp_mode_o}, 8'h02, "R2 plot");
        chk({3'd0, cmd_strobe_o}, 8'h00, "R7 no strobe");
        step(3);
        chk({6'd0, plot_mode_o, spp_mode_o}, 8'h02, "R2 hold");
        wr(8'h40);
        chk({6'd0, plot_mode_o, spp_mode_o}, 8'h01, "R2 spp");
        wr(8'h00);
        chk({6'd0, plot_mode_o, spp_mode_o}, 8'h00, "R2 print");
        wr(8'hA0);
        chk({6'd0, plot_mode_o, spp_mode_o}, 8'h02, "R3 bit5 ignored");
        chk({3'd0, cmd_strobe_o}, 8'h00, "R3 no strobe");
        chk(rd_data & 8'h20, 8'h00, "R3 status bit5");
    endtask

    task automatic t_pulse(input logic [7:0] d, input string tag);
        wr(d);
        for (int i = 0; i < P; i++) begin
            chk({3'd0, cmd_strobe_o}, {3'd0, d[4:0]}, tag);
            if (i < P - 1) step(1);
        end
        step(1);
        chk({3'd0, cmd_strobe_o}, 8'h00, tag);
        step(1);
    endtask

    task automatic t_mode_with_cmd();
        wr(8'h90);
        chk({6'd0, plot_mode_o, spp_mode_o}, 8'h02, "R5 mode set");
        chk({3'd0, cmd_strobe_o}, 8'h10, "R5 strobe");
        step(P);
        chk({6'd0, plot_mode_o, spp_mode_o}, 8'h02, "R5 mode kept");
        chk({3'd0, cmd_strobe_o}, 8'h00, "R5 strobe end");
        wr(8'h08);
        chk({6'd0, plot_mode_o, spp_mode_o}, 8'h00, "R5 mode from cmd write");
        step(P + 1);
    endtask

    task automatic t_queue();
        wr(8'h10);
        wr(8'h08);
        chk({3'd0, cmd_strobe_o}, 8'h10, "R6 first still");
        step(2);
        chk({3'd0, cmd_strobe_o}, 8'h10, "R6 first last");
        step(1);
        chk({3'd0, cmd_strobe_o}, 8'h00, "R6 gap");
        for (int i = 0; i < P; i++) begin
            step(1);
            chk({3'd0, cmd_strobe_o}, 8'h08, "R6 queued");
        end
        step(1);
        chk({3'd0, cmd_strobe_o}, 8'h00, "R6 queued end");
        step(1);
    endtask

    task automatic t_last_cycle();
        wr(8'h04);
        step(P - 1);
        chk({3'd0, cmd_strobe_o}, 8'h04, "R6 last cycle");
        wr(8'h02);
        chk({3'd0, cmd_strobe_o}, 8'h00, "R6 collide gap");
        wr(8'h01);
        for (int i = 0; i < P; i++) begin
            chk({3'd0, cmd_strobe_o}, 8'h03, "R6 gap merge");
            step(1);
        end
        chk({3'd0, cmd_strobe_o}, 8'h00, "R6 merge end");
        step(1);
    endtask

    task automatic t_status();
        wr(8'hC0);
        paper_i = 1'b1; online_i = 1'b0; dreq_i = 1'b1; ready_i = 1'b0;
        step(1);
        chk(rd_data, 8'hC0, "R8 sync latency");
        step(S - 1);
        chk(rd_data, 8'hD4, "R9 paper only");
        online_i = 1'b1; ready_i = 1'b1; dreq_i = 1'b0;
        step(S);
        chk(rd_data, 8'hCF, "R9 ok");
        paper_i = 1'b0;
        step(S);
        chk(rd_data, 8'hCA, "R9 online only");
    endtask

    task automatic t_reset_mid();
        wr(8'h82);
        wr(8'h84);
        chk({3'd0, cmd_strobe_o}, 8'h02, "R10 pre");
        rst_n = 1'b0;
        step(1);
        chk({3'd0, cmd_strobe_o}, 8'h00, "R10 cancel");
        chk({6'd0, plot_mode_o, spp_mode_o}, 8'h00, "R1 mode reset");
        rst_n = 1'b1;
        for (int i = 0; i < P + 3; i++) begin
            step(1);
            chk({3'd0, cmd_strobe_o}, 8'h00, "R10 queue discarded");
        end
    endtask

    initial begin
        step(1);
        t_reset();
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_mode();
        t_pulse(8'h10, "R4 eot");
        t_pulse(8'h01, "R4 remote reset");
        t_pulse(8'h1F, "R4 all");
        t_mode_with_cmd();
        t_queue();
        t_last_cycle();
        t_status();
        t_reset_mid();
        do_reset();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule